// File: doc/BRIEF.md
# Byte-Addressed GPIO Controller with Interrupt Merging

This block drives and samples a row of general-purpose pins. Software reaches it through a byte-wide register port. Every pin owns one byte in each configuration bank, and only bit 0 of that byte means anything. A pin is either a driven output or an input. An output drives the level held in its output byte. An input is brought into the clock domain through a two-flop synchronizer and can be read back.

Each pin also has its own trigger detector. The detector can be set to active-high level, active-low level, rising edge, falling edge, or both edges. A detected event sets a sticky pending bit, and software removes it by writing 1 to that pin's clear byte. A pin can become pending even while its interrupt is disabled. Only pins that are both pending and enabled reach the parent lines. Those pins are merged onto a small set of parent interrupt outputs, with pin i feeding parent line i mod NUM_PARENTS.

Top module: `gpio_byte_irq_ctrl`

## Requirements
- R1: After reset, every bank reads 0. pad_oe, pad_out and irq_out are all 0, and pad_oe stays 0 for a pin until its direction byte has been written at least once.
- R2: The direction byte of pin p sits at 0x800+p. Writing 1 makes the pin an input (pad_oe low). Writing 0 makes it an output (pad_oe high). A read returns the stored bit.
- R3: The output byte of pin p sits at 0x900+p and drives pad_out[p] at all times. Its value is kept while the pin is an input, so a pin switched to output drives the level written earlier.
- R4: The input byte of pin p sits at 0xA00+p and reads the pad value after two synchronizer stages. A pad change is visible after the second rising clock edge, not after the first.
- R5: The trigger is set by edge (0xD00+p), polarity (0xC00+p) and dual (0xF80+p). With edge=0, polarity 1 selects active-high level and polarity 0 selects active-low level, and dual is ignored. Under a level trigger the pending bit is set on every cycle the active level is present, so a clear write has no lasting effect until the level is gone.
- R6: With edge=1 and dual=0, polarity 1 selects the rising edge and polarity 0 selects the falling edge. The opposite transition does not set the pending bit, and once cleared the bit stays clear while the pad is stable.
- R7: With edge=1 and dual=1, both transitions set the pending bit, whatever the polarity.
- R8: Writing a byte with bit 0 set to 0xE00+p clears pin p's pending bit, which reads at 0xF00+p. Writing a byte with bit 0 clear has no effect.
- R9: A pin's pending bit latches even when its enable byte (0xB00+p) is 0. Such a pin does not drive any parent line. Enabling it later raises its parent line at once.
- R10: irq_out[k] is the OR of pins that are both pending and enabled and whose index mod NUM_PARENTS equals k. Clearing one pin leaves the line high while another pin on that line is still pending.
- R11: Writes to the input and status banks, to pin indices at or above NUM_PINS, and to addresses outside the banks change nothing. Such reads return 0. Only bit 0 of a written byte is stored, and reads return it in bit 0 with bits 7:1 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address: bank in bits 11:8, pin index in the low bits |
| reg_wdata | input | 8 | Write data; bit 0 is stored |
| reg_rdata | output | 8 | Read data for reg_addr, combinational from state |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Levels driven to the pads |
| pad_oe | output | NUM_PINS | Output enables, high for configured output pins |
| irq_out | output | NUM_PARENTS | Merged parent interrupt lines |

## Verification
The trigger detector is tried under five patterns, and each is chosen to expose a different wrong decode. A sustained high or low level, held across a clear write, separates level mode from edge mode. A single rising or falling transition in each single-edge polarity catches a swapped polarity. A falling then rising sequence under dual-edge with polarity 0 shows whether polarity is wrongly applied in that mode. A short low pulse on pins that share a parent line, one clear at a time, tests the merge by index modulo and its OR behaviour. A pulse on a disabled pin followed by a late enable tests the gating of pending pins.

// File: rtl/gbi_pkg.sv
package gbi_pkg;

    localparam int unsigned ADDR_W = 12;

    // Bank selector held in address bits 11:8; bank F splits on bit 7.
    typedef enum logic [3:0] {
        BK_DIR  = 4'h8,
        BK_OUT  = 4'h9,
        BK_IN   = 4'hA,
        BK_EN   = 4'hB,
        BK_POL  = 4'hC,
        BK_EDGE = 4'hD,
        BK_CLR  = 4'hE,
        BK_HI   = 4'hF
    } bank_e;

    typedef enum logic [2:0] {
        TRIG_LVL_LO,
        TRIG_LVL_HI,
        TRIG_FALL,
        TRIG_RISE,
        TRIG_BOTH
    } trig_e;

    function automatic trig_e decode_trig(input logic edg, input logic pol, input logic dual);
        if (edg && dual)  return TRIG_BOTH;
        else if (edg)     return pol ? TRIG_RISE : TRIG_FALL;
        else              return pol ? TRIG_LVL_HI : TRIG_LVL_LO;
    endfunction

endpackage

// File: rtl/gbi_sync.sv
module gbi_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] meta_d, meta_q;
    logic [WIDTH-1:0] sync_d, sync_q;
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        meta_d = raw_i;
        sync_d = meta_q;
        prev_d = sync_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign lvl_o  = sync_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/gbi_event.sv
module gbi_event
    import gbi_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] prev_i,
    input  logic [WIDTH-1:0] edg_i,
    input  logic [WIDTH-1:0] pol_i,
    input  logic [WIDTH-1:0] dual_i,
    output logic [WIDTH-1:0] evt_o
);

    function automatic logic fire(input trig_e t, input logic cur, input logic old);
        case (t)
            TRIG_LVL_HI: return cur;
            TRIG_LVL_LO: return !cur;
            TRIG_RISE:   return cur && !old;
            TRIG_FALL:   return !cur && old;
            TRIG_BOTH:   return cur != old;
            default:     return 1'b0;
        endcase
    endfunction

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        assign evt_o[g] = fire(decode_trig(edg_i[g], pol_i[g], dual_i[g]), lvl_i[g], prev_i[g]);
    end

endmodule

// File: rtl/gbi_merge.sv
module gbi_merge #(
    parameter int unsigned WIDTH   = 16,
    parameter int unsigned PARENTS = 7
) (
    input  logic [WIDTH-1:0]   src_i,
    output logic [PARENTS-1:0] line_o
);

    for (genvar k = 0; k < PARENTS; k++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < WIDTH; i++) begin
                if ((i % PARENTS) == k) hit = hit | src_i[i];
            end
        end
        assign line_o[k] = hit;
    end

endmodule

// File: rtl/gpio_byte_irq_ctrl.sv
module gpio_byte_irq_ctrl
    import gbi_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 16,
    parameter int unsigned NUM_PARENTS = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic [NUM_PINS-1:0]    pad_in,
    output logic [NUM_PINS-1:0]    pad_out,
    output logic [NUM_PINS-1:0]    pad_oe,
    output logic [NUM_PARENTS-1:0] irq_out
);

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] out;
        logic [NUM_PINS-1:0] ien;
        logic [NUM_PINS-1:0] pol;
        logic [NUM_PINS-1:0] edg;
        logic [NUM_PINS-1:0] dual;
        logic [NUM_PINS-1:0] sts;
        logic [NUM_PINS-1:0] dset;
    } bank_t;

    bank_t               r_d, r_q;
    bank_e               bank;
    logic                hi_half;
    logic [7:0]          idx;
    logic [NUM_PINS-1:0] pin_sel;
    logic [NUM_PINS-1:0] clr_hit;
    logic [NUM_PINS-1:0] lvl_s, prev_s, evt;
    logic                rd_bit;

    // Address decode: bank F carries status (low half) and dual (high half).
    assign bank    = bank_e'(reg_addr[11:8]);
    assign hi_half = reg_addr[7];
    assign idx     = (bank == BK_HI) ? {1'b0, reg_addr[6:0]} : reg_addr[7:0];

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            pin_sel[i] = (idx == 8'(i));
        end
        clr_hit = (reg_we && bank == BK_CLR && reg_wdata[0]) ? pin_sel : '0;
    end

    gbi_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .lvl_o  (lvl_s),
        .prev_o (prev_s)
    );

    gbi_event #(.WIDTH(NUM_PINS)) u_event (
        .lvl_i  (lvl_s),
        .prev_i (prev_s),
        .edg_i  (r_q.edg),
        .pol_i  (r_q.pol),
        .dual_i (r_q.dual),
        .evt_o  (evt)
    );

    gbi_merge #(.WIDTH(NUM_PINS), .PARENTS(NUM_PARENTS)) u_merge (
        .src_i  (r_q.sts & r_q.ien),
        .line_o (irq_out)
    );

    // Next-state: configuration writes and sticky pending bits.
    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (reg_we && pin_sel[i]) begin
                case (bank)
                    BK_DIR: begin
                        r_d.dir[i]  = reg_wdata[0];
                        r_d.dset[i] = 1'b1;
                    end
                    BK_OUT:  r_d.out[i] = reg_wdata[0];
                    BK_EN:   r_d.ien[i] = reg_wdata[0];
                    BK_POL:  r_d.pol[i] = reg_wdata[0];
                    BK_EDGE: r_d.edg[i] = reg_wdata[0];
                    BK_HI:   if (hi_half) r_d.dual[i] = reg_wdata[0];
                    default: ;
                endcase
            end
            // An event in the same cycle as a clear wins.
            r_d.sts[i] = (r_q.sts[i] & ~clr_hit[i]) | evt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Read path.
    always_comb begin
        rd_bit = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pin_sel[i]) begin
                case (bank)
                    BK_DIR:  rd_bit = r_q.dir[i];
                    BK_OUT:  rd_bit = r_q.out[i];
                    BK_IN:   rd_bit = lvl_s[i];
                    BK_EN:   rd_bit = r_q.ien[i];
                    BK_POL:  rd_bit = r_q.pol[i];
                    BK_EDGE: rd_bit = r_q.edg[i];
                    BK_HI:   rd_bit = hi_half ? r_q.dual[i] : r_q.sts[i];
                    default: rd_bit = 1'b0;
                endcase
            end
        end
        reg_rdata = {7'b0, rd_bit};
    end

    assign pad_out = r_q.out;
    assign pad_oe  = r_q.dset & ~r_q.dir;

endmodule

// File: rtl/gbi_chk.sv
module gbi_chk #(
    parameter int unsigned NUM_PINS    = 16,
    parameter int unsigned NUM_PARENTS = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_we,
    input logic [11:0]            reg_addr,
    input logic                   wbit0,
    input logic [NUM_PARENTS-1:0] irq_out,
    input logic [6*NUM_PINS-1:0]  cfg,
    input logic [NUM_PINS-1:0]    sts,
    input logic [NUM_PINS-1:0]    ien,
    input logic [NUM_PINS-1:0]    edg,
    input logic [NUM_PINS-1:0]    pol,
    input logic [NUM_PINS-1:0]    lvl,
    input logic [NUM_PINS-1:0]    prev,
    input logic [NUM_PINS-1:0]    evt
);

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> ((sts & ien) != '0));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ien) == '0) |-> (irq_out == '0));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> $stable(cfg));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // R6
        edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(sts[i]) && $past(edg[i])) |-> ($past(lvl[i]) != $past(prev[i])));

        // R5
        level_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(sts[i]) && !$past(edg[i])) |-> ($past(lvl[i]) == $past(pol[i])));

        // R8
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(reg_we) && $past(reg_addr) == (12'hE00 + 12'(i)) && $past(wbit0) && !$past(evt[i]))
            |-> !sts[i]);
    end

endmodule

bind gpio_byte_irq_ctrl gbi_chk #(
    .NUM_PINS    (NUM_PINS),
    .NUM_PARENTS (NUM_PARENTS)
) u_gbi_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wbit0    (reg_wdata[0]),
    .irq_out  (irq_out),
    .cfg      ({r_q.dir, r_q.out, r_q.ien, r_q.pol, r_q.edg, r_q.dual}),
    .sts      (r_q.sts),
    .ien      (r_q.ien),
    .edg      (r_q.edg),
    .pol      (r_q.pol),
    .lvl      (lvl_s),
    .prev     (prev_s),
    .evt      (evt)
);

// File: tb/gpio_byte_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_byte_irq_ctrl_bench;

    localparam int NP = 16;
    localparam int NQ = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] pad_in = '1;
    logic [NP-1:0] pad_out, pad_oe;
    logic [NQ-1:0] irq_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_byte_irq_ctrl #(.NUM_PINS(NP), .NUM_PARENTS(NQ)) u_gpio_byte_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    localparam logic [11:0] A_DIR = 12'h800, A_OUT = 12'h900, A_IN = 12'hA00,
                            A_EN = 12'hB00, A_POL = 12'hC00, A_EDGE = 12'hD00,
                            A_CLR = 12'hE00, A_STS = 12'hF00, A_DUAL = 12'hF80;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [7:0] exp, input string req, input string what);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        check(req, what, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic expect_irq(input logic [NQ-1:0] exp, input string req, input string what);
        @(negedge clk);
        #0.5;
        check(req, what, 32'(irq_out), 32'(exp));
    endtask

    task automatic pad_set(input int p, input logic v);
        @(negedge clk);
        pad_in[p] = v;
    endtask

    task automatic pulse_low(input int p);
        pad_set(p, 1'b0);
        pad_set(p, 1'b1);
        waitn(2);
    endtask

    task automatic t_reset();
        waitn(2);
        expect_rd(A_DIR + 0, 8'h00, "R1", "dir pin0 in reset");
        expect_rd(A_OUT + 5, 8'h00, "R1", "out pin5 in reset");
        expect_rd(A_EN + 4, 8'h00, "R1", "enable pin4 in reset");
        expect_rd(A_STS + 3, 8'h00, "R1", "status pin3 in reset");
        check("R1", "pad_oe in reset", 32'(pad_oe), 32'h0);
        check("R1", "pad_out in reset", 32'(pad_out), 32'h0);
        check("R1", "irq_out in reset", 32'(irq_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        waitn(4);
        check("R1", "pad_oe before direction write", 32'(pad_oe), 32'h0);
        for (int p = 0; p < NP; p++) wr(A_CLR + 12'(p), 8'h01);
        expect_rd(A_STS + 0, 8'h00, "R1", "status pin0 after clearing");
        expect_irq('0, "R1", "irq_out idle");
    endtask

    task automatic t_direction();
        wr(A_DIR + 3, 8'h00);
        @(negedge clk); #0.5;
        check("R2", "pad_oe after output select", 32'(pad_oe), 32'h0008);
        wr(A_OUT + 3, 8'h01);
        @(negedge clk); #0.5;
        check("R2", "pad_out pin3", 32'(pad_out[3]), 32'h1);
        expect_rd(A_DIR + 3, 8'h00, "R2", "dir pin3 readback 0");
        wr(A_DIR + 3, 8'h01);
        @(negedge clk); #0.5;
        check("R2", "pad_oe pin3 after input select", 32'(pad_oe[3]), 32'h0);
        expect_rd(A_DIR + 3, 8'h01, "R2", "dir pin3 readback 1");
    endtask

    task automatic t_retain();
        wr(A_DIR + 5, 8'h01);
        wr(A_OUT + 5, 8'hFF);
        expect_rd(A_OUT + 5, 8'h01, "R11", "out pin5 keeps only bit0");
        check("R3", "pad_oe pin5 as input", 32'(pad_oe[5]), 32'h0);
        check("R3", "pad_out pin5 held while input", 32'(pad_out[5]), 32'h1);
        wr(A_DIR + 5, 8'h00);
        @(negedge clk); #0.5;
        check("R3", "pad_oe pin5 as output", 32'(pad_oe[5]), 32'h1);
        check("R3", "pad_out pin5 drives earlier level", 32'(pad_out[5]), 32'h1);
        wr(A_OUT + 5, 8'hFE);
        @(negedge clk); #0.5;
        check("R11", "pad_out pin5 from bit0 of 0xFE", 32'(pad_out[5]), 32'h0);
    endtask

    task automatic t_input();
        pad_set(2, 1'b0);
        expect_rd(A_IN + 2, 8'h01, "R4", "input pin2 after one edge");
        expect_rd(A_IN + 2, 8'h00, "R4", "input pin2 after two edges");
        pad_set(2, 1'b1);
        waitn(3);
        expect_rd(A_IN + 2, 8'h01, "R4", "input pin2 back high");
        wr(A_CLR + 2, 8'h01);
    endtask

    task automatic t_level();
        wr(A_EDGE + 4, 8'h01);
        wr(A_POL + 4, 8'h01);
        pad_set(4, 1'b0);
        waitn(3);
        wr(A_EDGE + 4, 8'h00);
        wr(A_CLR + 4, 8'h01);
        wr(A_EN + 4, 8'h01);
        expect_rd(A_STS + 4, 8'h00, "R5", "level-high idle with pad low");
        pad_set(4, 1'b1);
        waitn(2);
        expect_rd(A_STS + 4, 8'h01, "R5", "level-high pending");
        check("R5", "irq line 4 for level-high", 32'(irq_out), 32'h10);
        wr(A_CLR + 4, 8'h01);
        expect_rd(A_STS + 4, 8'h01, "R5", "clear ignored while level high");
        pad_set(4, 1'b0);
        waitn(3);
        wr(A_CLR + 4, 8'h01);
        expect_rd(A_STS + 4, 8'h00, "R5", "clear after level gone");
        wr(A_POL + 4, 8'h00);
        expect_rd(A_STS + 4, 8'h01, "R5", "level-low pending");
        pad_set(4, 1'b1);
        waitn(3);
        wr(A_CLR + 4, 8'h01);
        expect_rd(A_STS + 4, 8'h00, "R5", "level-low released");
        wr(A_EN + 4, 8'h00);
        expect_irq('0, "R5", "irq idle after level test");
    endtask

    task automatic t_edge();
        wr(A_EDGE + 6, 8'h01);
        wr(A_POL + 6, 8'h01);
        wr(A_CLR + 6, 8'h01);
        wr(A_EN + 6, 8'h01);
        pad_set(6, 1'b0);
        waitn(3);
        expect_rd(A_STS + 6, 8'h00, "R6", "falling ignored under rising");
        pad_set(6, 1'b1);
        waitn(2);
        expect_rd(A_STS + 6, 8'h01, "R6", "rising sets pending");
        check("R6", "irq line 6", 32'(irq_out), 32'h40);
        wr(A_CLR + 6, 8'h01);
        waitn(2);
        expect_rd(A_STS + 6, 8'h00, "R6", "stays clear while pad stable");
        wr(A_POL + 6, 8'h00);
        pad_set(6, 1'b0);
        waitn(2);
        expect_rd(A_STS + 6, 8'h01, "R6", "falling sets pending");
        wr(A_CLR + 6, 8'h01);
        pad_set(6, 1'b1);
        waitn(2);
        expect_rd(A_STS + 6, 8'h00, "R6", "rising ignored under falling");
        wr(A_EN + 6, 8'h00);
    endtask

    task automatic t_dual();
        wr(A_EDGE + 8, 8'h01);
        wr(A_DUAL + 8, 8'h01);
        expect_rd(A_DUAL + 8, 8'h01, "R7", "dual pin8 readback");
        wr(A_CLR + 8, 8'h01);
        pad_set(8, 1'b0);
        waitn(2);
        expect_rd(A_STS + 8, 8'h01, "R7", "dual falling sets");
        wr(A_CLR + 8, 8'h01);
        expect_rd(A_STS + 8, 8'h00, "R7", "dual cleared");
        pad_set(8, 1'b1);
        waitn(2);
        expect_rd(A_STS + 8, 8'h01, "R7", "dual rising sets with polarity 0");
        wr(A_CLR + 8, 8'h01);
    endtask

    task automatic t_clear_zero();
        pad_set(8, 1'b0);
        waitn(2);
        expect_rd(A_STS + 8, 8'h01, "R8", "pin8 pending");
        wr(A_CLR + 8, 8'h00);
        expect_rd(A_STS + 8, 8'h01, "R8", "clear with 0x00 ignored");
        wr(A_CLR + 8, 8'h02);
        expect_rd(A_STS + 8, 8'h01, "R8", "clear with 0x02 ignored");
        wr(A_CLR + 8, 8'h01);
        expect_rd(A_STS + 8, 8'h00, "R8", "clear with 0x01");
        pad_set(8, 1'b1);
        waitn(3);
        wr(A_CLR + 8, 8'h01);
    endtask

    task automatic t_disabled();
        wr(A_EDGE + 9, 8'h01);
        wr(A_POL + 9, 8'h01);
        wr(A_CLR + 9, 8'h01);
        pulse_low(9);
        expect_rd(A_STS + 9, 8'h01, "R9", "status latches while disabled");
        check("R9", "no parent line while disabled", 32'(irq_out), 32'h0);
        wr(A_EN + 9, 8'h01);
        expect_irq(7'h04, "R9", "late enable raises line 2");
        wr(A_EN + 9, 8'h00);
        expect_irq(7'h00, "R9", "disable drops line 2");
        wr(A_CLR + 9, 8'h01);
    endtask

    task automatic t_merge();
        for (int n = 0; n < 3; n++) begin
            int p;
            p = (n == 0) ? 7 : (n == 1) ? 14 : 11;
            wr(A_EDGE + 12'(p), 8'h01);
            wr(A_POL + 12'(p), 8'h01);
            wr(A_CLR + 12'(p), 8'h01);
            wr(A_EN + 12'(p), 8'h01);
        end
        expect_irq(7'h00, "R10", "merge idle");
        pulse_low(7);
        expect_irq(7'h01, "R10", "pin7 on line 0");
        pulse_low(14);
        expect_irq(7'h01, "R10", "pin14 shares line 0");
        wr(A_CLR + 7, 8'h01);
        expect_irq(7'h01, "R10", "line 0 held by pin14");
        pulse_low(11);
        expect_irq(7'h11, "R10", "pin11 adds line 4");
        wr(A_CLR + 14, 8'h01);
        expect_irq(7'h10, "R10", "line 0 drops");
        wr(A_CLR + 11, 8'h01);
        expect_irq(7'h00, "R10", "all lines drop");
    endtask

    task automatic t_ignored();
        wr(A_STS + 10, 8'h01);
        expect_rd(A_STS + 10, 8'h00, "R11", "status bank not writable");
        wr(A_IN + 10, 8'h00);
        expect_rd(A_IN + 10, 8'h01, "R11", "input bank not writable");
        wr(A_DIR + 20, 8'h00);
        expect_rd(A_DIR + 20, 8'h00, "R11", "pin beyond range reads 0");
        check("R11", "pad_oe unchanged by out-of-range write", 32'(pad_oe), 32'h0020);
        wr(12'h020, 8'h01);
        expect_rd(12'h020, 8'h00, "R11", "address outside banks reads 0");
        expect_rd(A_CLR + 3, 8'h00, "R11", "clear bank reads 0");
    endtask

    initial begin
        t_reset();
        t_direction();
        t_retain();
        t_input();
        t_level();
        t_edge();
        t_dual();
        t_clear_zero();
        t_disabled();
        t_merge();
        t_ignored();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule